// File: doc/BRIEF.md
# Parallel Prefix Magnitude Comparator

This block compares two unsigned operands of a parameterised width and reports which one is larger. A bitwise stage first classifies every bit position as "same", "A has the one" or "B has the one". A log-depth prefix network then works out, for each position, whether any more significant position already differs. Only the most significant differing position survives onto one of two buses. A bit on the A-wins bus means A is larger, a bit on the B-wins bus means B is larger. A decision stage OR-reduces each bus into three exclusive flags.

Every combining cell in the prefix network and in the bus gating is a 2:1 multiplexer. Each level only combines a position with the one 2^k places above it, so the fan-in and fan-out of every cell stay fixed whatever the width. The block is combinational by default. Setting `REG_OUT` adds one output register stage, which is cleared by an asynchronous active-low reset.

Top module: `ppc_mag_cmp`

## Requirements
- R1: A bit position where a_i and b_i hold the same value drives 0 on both left_bus_o and right_bus_o at that position.
- R2: At the most significant position where a_i and b_i differ, left_bus_o carries 1 if a_i holds the 1 there, and right_bus_o carries 1 if b_i holds the 1 there.
- R3: Every bus bit below the most significant differing position is 0 on both buses, whatever the lower operand bits are.
- R4: left_bus_o and right_bus_o each have at most one bit set, and they are never both nonzero at the same time.
- R5: gt_o is 1 exactly when left_bus_o is nonzero, lt_o is 1 exactly when right_bus_o is nonzero, and eq_o is 1 exactly when both buses are zero.
- R6: Outside reset, exactly one of eq_o, gt_o, lt_o is 1 for any input pair.
- R7: The flags follow unsigned magnitude order: gt_o when a_i > b_i, lt_o when a_i < b_i, eq_o when a_i == b_i. The operands 0x005D and 0x0069 give right_bus_o = 0x0020 and lt_o = 1.
- R8: With REG_OUT = 1, the outputs show the result for the inputs sampled at the previous rising clk_i edge. While rst_ni is low, both buses and all three flags are 0. With REG_OUT = 0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| left_bus_o | output | WIDTH | One-hot mark of the first differing position where A has the 1 |
| right_bus_o | output | WIDTH | One-hot mark of the first differing position where B has the 1 |
| eq_o | output | 1 | Operands equal |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |

## Verification
A wrong prefix level shows up at once as a second set bit on a bus, or as a mark at a position below the true first difference. The reason is that some position fails to see a difference 2^k places above it. Both faults change the bus value in the same cycle as the input, or one cycle later when registered. A broken reduction or flag mapping gives flags that disagree with the bus contents or with unsigned order. A skewed register stage gives results that belong to the wrong input pair. Vectors that differ in only one bit at the MSB, the LSB or a random position, together with equal pairs, drive each prefix distance on its own.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } ppc_flags_t;

  // 2:1 mux used as the basic tree cell
  function automatic logic mux2(input logic sel, input logic d1, input logic d0);
    return sel ? d1 : d0;
  endfunction
endpackage

// File: rtl/ppc_bit_encode.sv
module ppc_bit_encode #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] a_win_o,
  output logic [WIDTH-1:0] b_win_o
);
  import ppc_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign diff_o[i]  = mux2(a_i[i], ~b_i[i], b_i[i]);
    assign a_win_o[i] = mux2(a_i[i], ~b_i[i], 1'b0);
    assign b_win_o[i] = mux2(b_i[i], ~a_i[i], 1'b0);
  end
endmodule

// File: rtl/ppc_prefix_tree.sv
// MSB-to-LSB prefix OR: above_o[i] = any diff at positions > i.
module ppc_prefix_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] diff_i,
  output logic [WIDTH-1:0] above_o
);
  import ppc_pkg::*;

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] lvl [LEVELS+1];

  assign lvl[0] = diff_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int DIST = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      if (i + DIST < WIDTH) begin : g_mux
        assign lvl[k+1][i] = mux2(lvl[k][i+DIST], 1'b1, lvl[k][i]);
      end else begin : g_pass
        assign lvl[k+1][i] = lvl[k][i];
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    if (i == WIDTH - 1) begin : g_top
      assign above_o[i] = 1'b0;
    end else begin : g_low
      assign above_o[i] = lvl[LEVELS][i+1];
    end
  end
endmodule

// File: rtl/ppc_decide.sv
module ppc_decide #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]      left_i,
  input  logic [WIDTH-1:0]      right_i,
  output ppc_pkg::ppc_flags_t   flags_o
);
  logic l_any, r_any;

  assign l_any      = |left_i;
  assign r_any      = |right_i;
  assign flags_o.gt = l_any;
  assign flags_o.lt = r_any;
  assign flags_o.eq = ~(l_any | r_any);
endmodule

// File: rtl/ppc_mag_cmp.sv
module ppc_mag_cmp #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] left_bus_o,
  output logic [WIDTH-1:0] right_bus_o,
  output logic             eq_o,
  output logic             gt_o,
  output logic             lt_o
);
  import ppc_pkg::*;

  logic [WIDTH-1:0] diff, a_win, b_win, above;
  logic [WIDTH-1:0] left_c, right_c;
  ppc_flags_t       flags_c;

  ppc_bit_encode #(.WIDTH(WIDTH)) u_enc (
    .a_i    (a_i),
    .b_i    (b_i),
    .diff_o (diff),
    .a_win_o(a_win),
    .b_win_o(b_win)
  );

  ppc_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .diff_i (diff),
    .above_o(above)
  );

  // kill every candidate that has a difference above it
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign left_c[i]  = mux2(above[i], 1'b0, a_win[i]);
    assign right_c[i] = mux2(above[i], 1'b0, b_win[i]);
  end

  ppc_decide #(.WIDTH(WIDTH)) u_dec (
    .left_i (left_c),
    .right_i(right_c),
    .flags_o(flags_c)
  );

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] left_q, right_q;
    ppc_flags_t       flags_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        left_q  <= '0;
        right_q <= '0;
        flags_q <= '0;
      end else begin
        left_q  <= left_c;
        right_q <= right_c;
        flags_q <= flags_c;
      end
    end
    assign left_bus_o  = left_q;
    assign right_bus_o = right_q;
    assign eq_o        = flags_q.eq;
    assign gt_o        = flags_q.gt;
    assign lt_o        = flags_q.lt;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk_i ^ rst_ni;
    assign left_bus_o  = left_c;
    assign right_bus_o = right_c;
    assign eq_o        = flags_c.eq;
    assign gt_o        = flags_c.gt;
    assign lt_o        = flags_c.lt;
  end
endmodule

// File: rtl/ppc_mag_cmp_chk.sv
module ppc_mag_cmp_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] left_bus_o,
  input logic [WIDTH-1:0] right_bus_o,
  input logic             eq_o,
  input logic             gt_o,
  input logic             lt_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  logic live;
  assign live = !REG_OUT || primed;

  assert_bus_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ($onehot0(left_bus_o) && $onehot0(right_bus_o) && ((left_bus_o & right_bus_o) == '0)));

  assert_one_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ($countones({eq_o, gt_o, lt_o}) == 1));

  assert_flag_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ((gt_o == (left_bus_o != '0)) && (lt_o == (right_bus_o != '0))));

  if (REG_OUT) begin : g_seq
    assert_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> ((gt_o == ($past(a_i) > $past(b_i))) && (lt_o == ($past(a_i) < $past(b_i)))));
  end else begin : g_comb
    assert_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gt_o == (a_i > b_i)) && (lt_o == (a_i < b_i)) && (eq_o == (a_i == b_i)));
    assert_same_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((~(a_i ^ b_i)) & (left_bus_o | right_bus_o)) == '0);
  end
endmodule

bind ppc_mag_cmp ppc_mag_cmp_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/ppc_mag_cmp_tb.sv
`timescale 1ns/1ps
module ppc_mag_cmp_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] l_c, r_c, l_r, r_r;
  logic         eq_c, gt_c, lt_c, eq_r, gt_r, lt_r;
  int           checks = 0, failures = 0;
  logic [W-1:0] pa = '0, pb = '0;

  always #10 clk = ~clk;

  ppc_mag_cmp #(.WIDTH(W), .REG_OUT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .left_bus_o(l_c), .right_bus_o(r_c), .eq_o(eq_c), .gt_o(gt_c), .lt_o(lt_c));

  ppc_mag_cmp #(.WIDTH(W), .REG_OUT(1'b1)) dut_reg_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .left_bus_o(l_r), .right_bus_o(r_r), .eq_o(eq_r), .gt_o(gt_r), .lt_o(lt_r));

  function automatic logic [W-1:0] exp_bus(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i] != y[i]) begin
        if (x[i]) r[i] = 1'b1;
        return r;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h)", req, act, exp, a, b);
    end
  endtask

  task automatic check_comb();
    logic [W-1:0] el = exp_bus(a, b);
    logic [W-1:0] er = exp_bus(b, a);
    chk(((l_c | r_c) & ~(a ^ b)) == '0, "R1", l_c | r_c, '0);
    chk(l_c == el, "R2 left", l_c, el);
    chk(r_c == er, "R3 right", r_c, er);
    chk(!((l_c != '0) && (r_c != '0)), "R4", l_c & r_c, '0);
    chk({gt_c, lt_c, eq_c} == {el != '0, er != '0, (el | er) == '0}, "R5",
        {13'b0, gt_c, lt_c, eq_c}, {13'b0, el != '0, er != '0, (el | er) == '0});
    chk($countones({eq_c, gt_c, lt_c}) == 1, "R6", {13'b0, eq_c, gt_c, lt_c}, '0);
    chk({gt_c, lt_c, eq_c} == {a > b, a < b, a == b}, "R7",
        {13'b0, gt_c, lt_c, eq_c}, {13'b0, a > b, a < b, a == b});
  endtask

  task automatic check_reg();
    logic [W-1:0] el = exp_bus(pa, pb);
    logic [W-1:0] er = exp_bus(pb, pa);
    chk(l_r == el && r_r == er, "R8 buses", l_r ^ r_r, el ^ er);
    chk({gt_r, lt_r, eq_r} == {pa > pb, pa < pb, pa == pb}, "R8 flags",
        {13'b0, gt_r, lt_r, eq_r}, {13'b0, pa > pb, pa < pb, pa == pb});
  endtask

  // drive at negedge, check comb shortly after, check registered one negedge later
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y;
    #2 check_comb();
    pa = x; pb = y;
    @(negedge clk);
    check_reg();
  endtask

  initial begin
    #4_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    a = 16'hFFFF; b = 16'h0000;
    #1;
    chk(l_r == '0 && r_r == '0 && {eq_r, gt_r, lt_r} == 3'b000, "R8 reset",
        l_r | r_r | {13'b0, eq_r, gt_r, lt_r}, '0);
    check_comb(); // R8: comb output live during reset
    @(negedge clk);
    rst_n = 1'b1;

    apply(16'h005D, 16'h0069); // R7 worked example
    chk(r_c == 16'h0020 && lt_c, "R7 example", r_c, 16'h0020);
    apply(16'h0000, 16'h0000);
    apply(16'hFFFF, 16'hFFFF);
    apply(16'hFFFF, 16'h0000);
    apply(16'h0000, 16'hFFFF);
    apply(16'h8000, 16'h7FFF); // R3: MSB only decides
    apply(16'h7FFF, 16'h8000);
    apply(16'h0001, 16'h0000);
    apply(16'h1234, 16'h1235);
    for (int k = 0; k < W; k++) apply(16'h5A5A, 16'h5A5A ^ (16'h1 << k));

    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] x = W'($urandom);
      logic [W-1:0] y;
      case ($urandom % 4)
        0: y = x;
        1: y = x ^ (W'(1) << ($urandom % W));
        2: y = x ^ (W'($urandom) & ~((W'(1) << ($urandom % W)) - 1'b1));
        default: y = W'($urandom);
      endcase
      apply(x, y);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule